// File: doc/BRIEF.md
# Event-to-Event Latency Counter

This block times the interval between two events on a datapath. Software picks a start source and a stop source, a count clock and a divide ratio, and then sets an enable bit. The block clears its counter and waits for a rising edge on the chosen start source. It then counts measurement ticks until a rising edge arrives on the chosen stop source. At that point it freezes the count and raises a ready flag that stays high until it is read.

Five event inputs are accepted. Two are start-side datapath markers (low-speed transmit, high-speed receive) and two are stop-side markers (low-speed receive, high-speed transmit). The fifth is one external pin that either side may select. Every event input is treated as asynchronous and passes through a synchronizer before edge detection.

Ticks come from one of two places. The first is the fast reference clock `clk`, which can be divided by 1, 2, 4 or 8. The second is a recovered-byte-clock strobe supplied in the `clk` domain, which is never divided. Each event can also carry a 4-bit marker tag, which is captured into latched status. Software reaches the block through a small register port with one-cycle read latency. Reading the status word clears its latched bits. `CNT_W` must lie between 17 and 20.

Top module: `lat_meas`

## Requirements
- R1: After reset the control word (address 0), the count word (address 1) and the status word (address 2) all read 0, and the block is idle.
- R2: When the enable bit (control bit 0) goes from 0 to 1, the count clears and the block waits for a start edge. Stop edges and edges on unselected start sources that arrive before the start edge have no effect on the result.
- R3: Start select (control bits 5:4) takes the low-speed transmit marker for code 00, the high-speed receive marker for code 01, and the external pin for codes 1x.
- R4: Stop select (control bits 7:6) takes the low-speed receive marker for code 00, the high-speed transmit marker for code 01, and the external pin for codes 1x. Edges on unselected stop sources during a measurement are ignored.
- R5: With the reference clock selected (control bit 1 = 0), divide code c (control bits 3:2) gives N = 2^c. If the selected start and stop inputs rise D clock cycles apart, the final count is floor(D/N).
- R6: With control bit 1 = 1, the count equals the number of cycles, within the same D-cycle window, in which `byte_tick` is high. The divide field has no effect in this mode.
- R7: When start and stop both select the external pin, the first rising edge starts the count and the next rising edge stops it.
- R8: The count saturates at 2^CNT_W − 1 and does not wrap.
- R9: The ready flag (status bit 12) is set when the stop edge freezes the count. It stays set until a read of address 2, and that read returns it before clearing it.
- R10: The start tag (status bits 7:4) and stop tag (status bits 11:8) take `start_tag_in` and `stop_tag_in`, ORed in at the accepted start edge and stop edge. They hold until a read of address 2 clears them.
- R11: Clearing the enable bit aborts a measurement in progress and returns the block to idle. Ready is not set, and stop edges that follow leave it clear.
- R12: Address 0 reads back control bits 7:0, and its upper byte reads 0. Address 1 holds count bits 15:0 and status bits 3:0 hold count bits 19:16, zero-filled above CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| byte_tick | input | 1 | Recovered-byte-clock strobe in `clk` domain |
| ls_tx_mark | input | 1 | Low-speed transmit marker (start source) |
| hs_rx_mark | input | 1 | High-speed receive marker (start source) |
| ls_rx_mark | input | 1 | Low-speed receive marker (stop source) |
| hs_tx_mark | input | 1 | High-speed transmit marker (stop source) |
| ext_evt | input | 1 | Shared external event pin |
| start_tag_in | input | 4 | Tag captured at the start edge |
| stop_tag_in | input | 4 | Tag captured at the stop edge |

## Verification
The assertions take several things for granted. Every event pulse stays high and then low long enough for the synchronizer to register both levels. The select, divide and clock-source fields stay fixed while a measurement is armed. The tag inputs are steady around the event that captures them. The stimulus meets these conditions as follows. Every event is driven as a two-cycle high pulse followed by two low cycles. Configuration is written only with the enable bit clear or in the same write that sets it. Tags are held constant for a whole measurement. All inputs change on the falling clock edge.

// File: rtl/lat_meas.sv
module lat_meas #(
  parameter int CNT_W  = 20,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        byte_tick,
  input  logic        ls_tx_mark,
  input  logic        hs_rx_mark,
  input  logic        ls_rx_mark,
  input  logic        hs_tx_mark,
  input  logic        ext_evt,
  input  logic [3:0]  start_tag_in,
  input  logic [3:0]  stop_tag_in
);
  localparam int NEV = 5;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_DONE} st_t;

  logic       ctl_en, ctl_bsel;
  logic [1:0] ctl_div, ctl_start, ctl_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      {ctl_stop, ctl_start, ctl_div, ctl_bsel, ctl_en} <= '0;
    else if (reg_wr && reg_addr == 2'd0)
      {ctl_stop, ctl_start, ctl_div, ctl_bsel, ctl_en} <= reg_wdata[7:0];
  end

  logic [NEV-1:0] ev_raw, ev_sync, ev_last, ev_rise;
  assign ev_raw = {ext_evt, hs_tx_mark, ls_rx_mark, hs_rx_mark, ls_tx_mark};

  genvar g;
  generate
    for (g = 0; g < NEV; g++) begin : g_sync
      logic [SYNC_N-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_N-2:0], ev_raw[g]};
      end
      assign ev_sync[g] = sh[SYNC_N-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_last <= '0;
    else        ev_last <= ev_sync;
  end
  assign ev_rise = ev_sync & ~ev_last;

  logic start_hit, stop_hit;
  assign start_hit = ctl_start[1] ? ev_rise[4] : (ctl_start[0] ? ev_rise[1] : ev_rise[0]);
  assign stop_hit  = ctl_stop[1]  ? ev_rise[4] : (ctl_stop[0]  ? ev_rise[3] : ev_rise[2]);

  logic [2:0] pre;
  logic [3:0] div_n;
  logic       tick;
  assign div_n = 4'd1 << ctl_div;
  assign tick  = ctl_bsel ? byte_tick : ({1'b0, pre} == div_n - 4'd1);

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic            ready_q;
  logic [3:0]      start_tag_q, stop_tag_q;
  logic            stat_rd;
  assign stat_rd = reg_rd && reg_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      pre         <= '0;
      ready_q     <= 1'b0;
      start_tag_q <= '0;
      stop_tag_q  <= '0;
    end else begin
      if (stat_rd) begin
        ready_q     <= 1'b0;
        start_tag_q <= '0;
        stop_tag_q  <= '0;
      end
      if (!ctl_en) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            st  <= S_WAIT;
            cnt <= '0;
          end
          S_WAIT: if (start_hit) begin
            st          <= S_RUN;
            pre         <= '0;
            start_tag_q <= start_tag_q | start_tag_in;
          end
          S_RUN: begin
            if (tick) begin
              pre <= '0;
              if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
            end else begin
              pre <= pre + 3'd1;
            end
            if (stop_hit) begin
              st         <= S_DONE;
              ready_q    <= 1'b1;
              stop_tag_q <= stop_tag_q | stop_tag_in;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [19:0] cnt_wide;
  assign cnt_wide = 20'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        2'd0:    reg_rdata <= {8'h00, ctl_stop, ctl_start, ctl_div, ctl_bsel, ctl_en};
        2'd1:    reg_rdata <= cnt_wide[15:0];
        2'd2:    reg_rdata <= {3'b000, ready_q, stop_tag_q, start_tag_q, cnt_wide[19:16]};
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

module lat_meas_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       st,
  input logic [CNT_W-1:0] cnt,
  input logic             ready
);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == 2'd0);

  // R11
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(st) == 2'd2 && $past(en)));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && cnt == '1) |=> cnt == '1);

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd2 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  // R2
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && en) |=> (st == 2'd1 && cnt == '0));

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && en) |=> $stable(cnt));
endmodule

bind lat_meas lat_meas_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (ctl_en),
  .st    (st),
  .cnt   (cnt),
  .ready (ready_q)
);

// File: tb/lat_meas_tb.sv
`timescale 1ns/1ps
module lat_meas_tb;
  localparam int CW = 17;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        byte_tick = 1'b0;
  logic [4:0]  ev = '0;
  logic [3:0]  start_tag_in = '0, stop_tag_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lat_meas #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .byte_tick(byte_tick),
    .ls_tx_mark(ev[0]), .hs_rx_mark(ev[1]), .ls_rx_mark(ev[2]),
    .hs_tx_mark(ev[3]), .ext_evt(ev[4]),
    .start_tag_in(start_tag_in), .stop_tag_in(stop_tag_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    step(1);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int i);
    ev[i] = 1'b1; step(2);
    ev[i] = 1'b0; step(2);
  endtask

  task automatic measure(input logic [1:0] ssel, input logic [1:0] psel, input bit bsel,
                         input logic [1:0] dv, input int d, input int exp,
                         input logic [3:0] ta, input logic [3:0] tb, input string req);
    int s, p, el;
    logic [15:0] v;
    s = ssel[1] ? 4 : (ssel[0] ? 1 : 0);
    p = psel[1] ? 4 : (psel[0] ? 3 : 2);
    start_tag_in = ta; stop_tag_in = tb;
    wr(2'd0, {8'h00, psel, ssel, dv, bsel, 1'b1});
    step(3);
    // R2: stop and unselected start edges before the start edge
    for (int i = 0; i < 5; i++) if (i != s) pulse(i);
    ev[s] = 1'b1; step(2); ev[s] = 1'b0; el = 2;
    // R4: unselected stop edges during the run
    for (int i = 0; i < 5; i++) if (i != s && i != p) begin pulse(i); el += 4; end
    step(d - el);
    ev[p] = 1'b1; step(2); ev[p] = 1'b0;
    step(6);
    rd(2'd1, v);
    check(v == exp[15:0], {req, " count low"}, v, exp[15:0]);
    rd(2'd2, v);
    check(v[3:0] == exp[19:16], {req, " R12 count high"}, v[3:0], exp[19:16]);
    check(v[12] == 1'b1, "R9 ready set", v[12], 1);
    check(v[7:4] == ta && v[11:8] == tb, "R10 tags", v[11:4], {tb, ta});
    rd(2'd2, v);
    check(v[12] == 1'b0 && v[11:4] == 8'h00, "R9 R10 read clears", v[12:4], 0);
    wr(2'd0, 16'h0000);
    step(3);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int idx, d, n, e;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1
    rd(2'd0, v); check(v == 16'h0, "R1 control", v, 0);
    rd(2'd1, v); check(v == 16'h0, "R1 count", v, 0);
    rd(2'd2, v); check(v == 16'h0, "R1 status", v, 0);
    // R12
    wr(2'd0, 16'hABFE);
    rd(2'd0, v); check(v == 16'h00FE, "R12 readback", v, 16'h00FE);
    wr(2'd0, 16'h0000);
    step(2);
    // R3 R4 R5 R7 sweep over sources and divide codes
    idx = 0;
    for (int ss = 0; ss < 3; ss++)
      for (int ps = 0; ps < 3; ps++)
        for (int dv = 0; dv < 4; dv++) begin
          d = 16 + (idx * 7) % 29;
          n = 1 << dv;
          e = d / n;
          measure(2'(ss == 2 ? 2 : ss), 2'(ps == 2 ? 3 : ps), 1'b0, 2'(dv), d, e,
                  4'(idx % 15 + 1), 4'(idx % 13 + 2),
                  (ss == 2 && ps == 2) ? "R7 shared pin" : "R3 R4 R5 sweep");
          idx++;
        end
    // R6: byte strobe counted, divider ignored
    byte_tick = 1'b1;
    measure(2'd1, 2'd1, 1'b1, 2'd3, 30, 30, 4'h3, 4'hC, "R6 byte strobe high");
    byte_tick = 1'b0;
    measure(2'd0, 2'd0, 1'b1, 2'd0, 25, 0, 4'h5, 4'hA, "R6 byte strobe low");
    // R11: abort
    wr(2'd0, 16'h0001);
    step(3);
    pulse(0);
    step(10);
    wr(2'd0, 16'h0000);
    step(3);
    pulse(2);
    step(5);
    rd(2'd2, v); check(v[12] == 1'b0, "R11 no ready after abort", v[12], 0);
    rd(2'd0, v); check(v == 16'h0, "R11 disabled", v, 0);
    // R8: saturation
    measure(2'd0, 2'd0, 1'b0, 2'd0, CMAX + 41, CMAX, 4'h1, 4'h2, "R8 saturate");
    done = 1;
    summary();
    $finish;
  end
endmodule